// File: doc/BRIEF.md
# Backplane Transmit Word Formatter

This block sits on the transmit side of a serial backplane link. On each word clock it turns a 32-bit payload and a 2-bit kind field into a 34-bit line word for a downstream serializer. The two overhead bits sit in bits 33:32 and the payload sits in bits 31:0. When no word is enabled, the block fills the slot with a fixed all-zero IDLE word. In framed mode the kind field picks a word type. In raw mode the kind field is copied into the overhead bits unchanged.

The block also carries link back pressure in both directions. The local ready-to-receive level is advertised to the far end through a flow-control word. That word is sent in a free slot whenever the level differs from what was last advertised. If data is holding the slot, the block drops its FIFO read-enable for one cycle to open one. A flow-control indication received from the far end holds the read-enable toward the upstream FIFO low. Both outputs are registered.

Top module: `bp_tx_framer`

## Requirements
- R1: While reset is high, `line_word` is all zeros (IDLE) and `fifo_rd_en` is low.
- R2: In framed mode (`raw_mode` low), a cycle with `tx_valid` high and `tx_kind` of 2'b01 (data), 2'b10 (control) or 2'b11 (flow control) gives `line_word = {tx_kind, tx_payload}` after the next clock edge.
- R3: A cycle with `tx_valid` low and no pending notice gives an all-zero IDLE word, whatever `tx_payload` and `tx_kind` hold.
- R4: In framed mode, a cycle with `tx_valid` high and `tx_kind` of 2'b00 gives an IDLE word.
- R5: In raw mode, a cycle with `tx_valid` high gives `line_word = {tx_kind, tx_payload}` with the kind bits copied unchanged, 2'b00 included.
- R6: The advertised ready state is "ready" after reset. In framed mode, when `local_ready` differs from the advertised state and `tx_valid` is low, the word is a notice: overhead 2'b11, payload bit 0 = 1 for pause or 0 for resume, and all other payload bits 0. The advertised state then takes the new value, so the next free slot is IDLE again.
- R7: When a notice is pending in framed mode and `tx_valid` is high, the data word keeps the slot. The notice stays pending, and `fifo_rd_en` is low after that edge.
- R8: `fifo_rd_en` is low after any edge at which `far_pause` was high. It is high after an edge at which `far_pause` was low, unless R7 applies.
- R9: In raw mode no notice is sent and `fifo_rd_en` is not dropped for a pending notice. A notice still pending when framed mode returns goes out in the first free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_payload | input | 32 | Payload word from upstream FIFO |
| tx_kind | input | 2 | Word kind (framed) or raw overhead bits (raw) |
| tx_valid | input | 1 | Payload and kind are to be sent this cycle |
| raw_mode | input | 1 | High: kind bits go straight into the overhead |
| local_ready | input | 1 | Local receive side can accept data |
| far_pause | input | 1 | Flow-control pause received from the far end |
| line_word | output | 34 | Registered line word: overhead in 33:32, payload in 31:0 |
| fifo_rd_en | output | 1 | Registered read-enable toward upstream FIFO |

## Verification
Two functions can meet in one slot: a pending ready-state notice and a valid data word. The bench provokes this by lowering `local_ready` while `tx_valid` is high. It then checks that the data word is emitted intact, that `fifo_rd_en` drops after that edge, and that the notice appears in the next idle slot with the correct pause bit. A second collision is checked too: a received pause held high together with data. There the data must still go out while only the read-enable falls.

// File: rtl/bp_tx_pkg.sv
package bp_tx_pkg;
  localparam int PAY_W  = 32;
  localparam int OH_W   = 2;
  localparam int WORD_W = PAY_W + OH_W;

  typedef enum logic [OH_W-1:0] {
    KIND_NONE = 2'b00,
    KIND_DATA = 2'b01,
    KIND_CTRL = 2'b10,
    KIND_FLOW = 2'b11
  } kind_e;

  localparam logic [WORD_W-1:0] IDLE_WORD = '0;
endpackage

// File: rtl/bp_tx_notice.sv
// Tracks the ready state last advertised to the far end.
module bp_tx_notice (
  input  logic clk,
  input  logic rst,
  input  logic local_ready,
  input  logic served,
  output logic pending,
  output logic pause_bit
);
  logic adv_ready_q;

  always_ff @(posedge clk) begin
    if (rst)         adv_ready_q <= 1'b1;
    else if (served) adv_ready_q <= local_ready;
  end

  always_comb begin
    pending   = (local_ready != adv_ready_q);
    pause_bit = ~local_ready;
  end

  // After serving, the advertised state matches the level that was served.
  assert_served_R6: assert property (@(posedge clk) disable iff (rst)
    served |=> (adv_ready_q == $past(local_ready)));
endmodule

// File: rtl/bp_tx_compose.sv
// Builds and registers the outgoing line word.
module bp_tx_compose
  import bp_tx_pkg::*;
#(
  parameter int P_W = PAY_W,
  parameter int O_W = OH_W,
  localparam int W_W = P_W + O_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] payload,
  input  logic [O_W-1:0] kind,
  input  logic           valid,
  input  logic           raw,
  input  logic           notice_go,
  input  logic           pause_bit,
  output logic [W_W-1:0] word_q
);
  logic [W_W-1:0] word_d;
  logic [P_W-1:0] notice_pay;

  always_comb begin
    notice_pay    = '0;
    notice_pay[0] = pause_bit;
    if (valid && raw)
      word_d = {kind, payload};
    else if (valid && (kind != O_W'(KIND_NONE)))
      word_d = {kind, payload};
    else if (notice_go)
      word_d = {O_W'(KIND_FLOW), notice_pay};
    else
      word_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_d;
  end

  assert_raw_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && raw) |=> (word_q == {$past(kind), $past(payload)}));
  assert_framed_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && !raw && kind != '0) |=> (word_q[W_W-1 -: O_W] == $past(kind)));
  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!valid && !notice_go) |=> (word_q == '0));
  assert_notice_R6: assert property (@(posedge clk) disable iff (rst)
    notice_go |=> (word_q[W_W-1 -: O_W] == '1));
endmodule

// File: rtl/bp_tx_rden.sv
// Registered read-enable toward the upstream FIFO.
module bp_tx_rden (
  input  logic clk,
  input  logic rst,
  input  logic far_pause,
  input  logic open_slot,
  output logic rd_en_q
);
  always_ff @(posedge clk) begin
    if (rst) rd_en_q <= 1'b0;
    else     rd_en_q <= ~far_pause & ~open_slot;
  end

  assert_pause_R8: assert property (@(posedge clk) disable iff (rst)
    far_pause |=> !rd_en_q);
  assert_slot_R7: assert property (@(posedge clk) disable iff (rst)
    open_slot |=> !rd_en_q);
endmodule

// File: rtl/bp_tx_framer.sv
module bp_tx_framer
  import bp_tx_pkg::*;
#(
  parameter int P_W = PAY_W,
  parameter int O_W = OH_W,
  localparam int W_W = P_W + O_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] tx_payload,
  input  logic [O_W-1:0] tx_kind,
  input  logic           tx_valid,
  input  logic           raw_mode,
  input  logic           local_ready,
  input  logic           far_pause,
  output logic [W_W-1:0] line_word,
  output logic           fifo_rd_en
);
  logic pending, pause_bit, notice_go, open_slot;

  // A notice uses only a free slot and only in framed mode.
  assign notice_go = pending & ~raw_mode & ~tx_valid;
  // Data holds the slot while a notice waits: ask upstream for a gap.
  assign open_slot = pending & ~raw_mode & tx_valid;

  bp_tx_notice u_notice (
    .clk(clk), .rst(rst), .local_ready(local_ready),
    .served(notice_go), .pending(pending), .pause_bit(pause_bit)
  );

  bp_tx_compose #(.P_W(P_W), .O_W(O_W)) u_compose (
    .clk(clk), .rst(rst), .payload(tx_payload), .kind(tx_kind),
    .valid(tx_valid), .raw(raw_mode), .notice_go(notice_go),
    .pause_bit(pause_bit), .word_q(line_word)
  );

  bp_tx_rden u_rden (
    .clk(clk), .rst(rst), .far_pause(far_pause),
    .open_slot(open_slot), .rd_en_q(fifo_rd_en)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (line_word == '0 && !fifo_rd_en));
  assert_rawquiet_R9: assert property (@(posedge clk) disable iff (rst)
    (raw_mode && !far_pause) |=> fifo_rd_en);
endmodule

// File: tb/sim_bp_tx_framer.sv
module sim_bp_tx_framer;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] tx_payload;
  logic [1:0]  tx_kind;
  logic        tx_valid, raw_mode, local_ready, far_pause;
  logic [33:0] line_word;
  logic        fifo_rd_en;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bp_tx_framer u0 (
    .clk(clk), .rst(rst), .tx_payload(tx_payload), .tx_kind(tx_kind),
    .tx_valid(tx_valid), .raw_mode(raw_mode), .local_ready(local_ready),
    .far_pause(far_pause), .line_word(line_word), .fifo_rd_en(fifo_rd_en)
  );

  task automatic check(string req, logic [33:0] exp_w, logic exp_r);
    checks++;
    if (line_word !== exp_w || fifo_rd_en !== exp_r) begin
      errors++;
      $display("FAIL %s: word=%h rd_en=%b expected word=%h rd_en=%b",
               req, line_word, fifo_rd_en, exp_w, exp_r);
    end
  endtask

  // Drive one cycle of inputs, then land on the falling edge after the capture.
  task automatic cyc(logic v, logic [1:0] k, logic [31:0] d,
                     logic raw, logic rdy, logic fp);
    tx_valid = v; tx_kind = k; tx_payload = d;
    raw_mode = raw; local_ready = rdy; far_pause = fp;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(1, 2'b01, 32'hDEADBEEF, 0, 1, 0);
    cyc(1, 2'b01, 32'hDEADBEEF, 0, 1, 0);
    check("R1", 34'h0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_framed;
    cyc(1, 2'b01, 32'h12345678, 0, 1, 0); check("R2 data", {2'b01, 32'h12345678}, 1);
    cyc(1, 2'b10, 32'hA5A5F00F, 0, 1, 0); check("R2 ctrl", {2'b10, 32'hA5A5F00F}, 1);
    cyc(1, 2'b11, 32'hFFFFFFFF, 0, 1, 0); check("R2 flow", {2'b11, 32'hFFFFFFFF}, 1);
  endtask

  task automatic t_idle;
    cyc(0, 2'b10, 32'hCAFEBABE, 0, 1, 0); check("R3", 34'h0, 1);
    cyc(0, 2'b11, 32'hFFFFFFFF, 1, 1, 0); check("R3 raw", 34'h0, 1);
    cyc(1, 2'b00, 32'h87654321, 0, 1, 0); check("R4", 34'h0, 1);
  endtask

  task automatic t_raw;
    cyc(1, 2'b00, 32'h0BADF00D, 1, 1, 0); check("R5 k00", {2'b00, 32'h0BADF00D}, 1);
    cyc(1, 2'b11, 32'h00000001, 1, 1, 0); check("R5 k11", {2'b11, 32'h00000001}, 1);
  endtask

  task automatic t_notice;
    cyc(0, 2'b00, 32'h55555555, 0, 0, 0); check("R6 pause", {2'b11, 32'h1}, 1);
    cyc(0, 2'b00, 32'h55555555, 0, 0, 0); check("R6 after", 34'h0, 1);
    cyc(0, 2'b00, 32'h0, 0, 1, 0);        check("R6 resume", {2'b11, 32'h0}, 1);
    cyc(0, 2'b00, 32'h0, 0, 1, 0);        check("R6 quiet", 34'h0, 1);
  endtask

  task automatic t_collide;
    cyc(1, 2'b01, 32'h11112222, 0, 0, 0); check("R7 data wins", {2'b01, 32'h11112222}, 0);
    cyc(0, 2'b00, 32'h0, 0, 0, 0);        check("R7 deferred", {2'b11, 32'h1}, 1);
    cyc(0, 2'b00, 32'h0, 0, 1, 0);        check("R7 resume", {2'b11, 32'h0}, 1);
  endtask

  task automatic t_far;
    cyc(0, 2'b00, 32'h0, 0, 1, 1);        check("R8 pause", 34'h0, 0);
    cyc(1, 2'b01, 32'h99887766, 0, 1, 1); check("R8 data", {2'b01, 32'h99887766}, 0);
    cyc(0, 2'b00, 32'h0, 0, 1, 0);        check("R8 release", 34'h0, 1);
  endtask

  task automatic t_raw_notice;
    cyc(0, 2'b00, 32'h0, 1, 0, 0);        check("R9 no notice", 34'h0, 1);
    cyc(1, 2'b10, 32'h44443333, 1, 0, 0); check("R9 no drop", {2'b10, 32'h44443333}, 1);
    cyc(0, 2'b00, 32'h0, 0, 0, 0);        check("R9 later", {2'b11, 32'h1}, 1);
    cyc(0, 2'b00, 32'h0, 0, 1, 0);        check("R9 resume", {2'b11, 32'h0}, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_framed();
    t_idle();
    t_raw();
    t_notice();
    t_collide();
    t_far();
    t_raw_notice();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule